// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sequences interrupt service for a small 8-bit core whose call stack is byte-wide and grows downward. It watches a vector of pending requests, an internally held global interrupt enable, a flag that says a multi-cycle instruction is still running, and a sleep indication. When it takes an interrupt, it stalls the core. It pushes the interrupted program counter as two bytes, clears the global enable and issues a vector fetch. It then runs a three-cycle jump phase and tells the core that the handler begins.

A return strobe from the core starts the reverse sequence. Two bytes are popped from the stack, the stack pointer rises by two, and the restored program counter is presented. The global enable is set again. If the core is asleep when an interrupt is taken, the sequencer first waits for a wake-up ready handshake and then adds a fixed extra delay before the normal entry. The stack memory lives outside the block and is read combinationally at the address the block drives.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, stall_o, gie_o, stk_we_o, stk_re_o, vec_valid_o, handler_start_o and ret_valid_o are 0, and sp_o equals the SP_INIT parameter.
- R2: An interrupt is taken at a clock edge only if the sequencer is idle, at least one irq_req_i bit is 1, gie_o is 1 and mc_busy_i is 0. Otherwise stall_o stays 0 and nothing is written to the stack.
- R3: In the first two cycles after an awake interrupt is taken, stk_we_o is 1. The first cycle writes the low PC byte (pc_i bits 7:0, sampled when the interrupt is taken) at address sp_o. The second writes the high byte (pc_i bits 15:8, zero-extended) at the decremented address. Each push lowers sp_o by 1.
- R4: The vector fetch (vec_valid_o) comes in the fifth cycle after an awake interrupt is taken, after the four entry cycles. vec_addr_o is twice the index of the lowest-numbered pending request, and irq_ack_o is that request's one-hot bit in the same cycle.
- R5: A three-cycle jump phase follows the vector cycle. handler_start_o is 1 in its third cycle, and the block is idle in the cycle after.
- R6: gie_o is 0 from the first cycle after an interrupt is taken until a return completes.
- R7: While mc_busy_i is 1, a pending interrupt is held off. It is taken at the first edge where mc_busy_i is 0.
- R8: If sleep_i is 1 when an interrupt is taken, the sequencer waits until wake_ready_i is 1. It then spends four more cycles before the entry, so every later event is delayed by the wait plus four cycles.
- R9: A return takes four cycles. The first cycle reads the high PC byte at sp_o+1 and the second reads the low byte at sp_o+2 (stk_re_o is 1 in both). ret_valid_o and ret_pc_o are given in the fourth cycle. Afterwards sp_o has risen by 2 and gie_o is 1.
- R10: In the idle state, gie_we_i loads gie_wdata_i into gie_o at the next edge. While a sequence is running, gie_we_i has no effect.
- R11: stall_o is 1 in every cycle from the first cycle after an interrupt or return is taken until the sequence ends.
- R12: If reti_i and an acceptable interrupt arrive in the same idle cycle, the return is taken first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | NUM_IRQ | Pending interrupt requests, bit 0 has highest priority |
| gie_we_i | input | 1 | Core write strobe for the global enable |
| gie_wdata_i | input | 1 | Value written to the global enable |
| mc_busy_i | input | 1 | A multi-cycle instruction is still executing |
| sleep_i | input | 1 | Core is in a sleep mode |
| wake_ready_i | input | 1 | Wake-up start-up has completed |
| reti_i | input | 1 | Return-from-interrupt strobe |
| pc_i | input | PC_W | Program counter to save on entry |
| stk_rdata_i | input | 8 | Stack read data at stk_addr_o |
| stk_we_o | output | 1 | Stack write strobe |
| stk_re_o | output | 1 | Stack read strobe |
| stk_addr_o | output | SP_W | Stack access address |
| stk_wdata_o | output | 8 | Stack write data |
| sp_o | output | SP_W | Stack pointer |
| vec_valid_o | output | 1 | Vector fetch strobe |
| vec_addr_o | output | PC_W | Vector address |
| irq_ack_o | output | NUM_IRQ | One-hot acknowledge of the served request |
| handler_start_o | output | 1 | Last jump cycle; handler runs next |
| ret_valid_o | output | 1 | Restored PC is valid |
| ret_pc_o | output | PC_W | Restored program counter |
| gie_o | output | 1 | Global interrupt enable |
| stall_o | output | 1 | Core stall during entry and return |

## Verification
On every cycle, the checker enforces the local rules. Stack writes happen only during a stall, and at the stack pointer. The pointer moves by one per push or pop, and pops read one above it. Acknowledges are one-hot and come only with an even vector address. The global enable is low at the vector cycle and high after a return. Some properties can only be shown by the bench's scenarios against its own stack and pointer model: the exact cycle counts of entry, sleep extension, jump and return, the priority choice, the byte order of the saved PC across nested interrupts, and that the enable write is ignored mid-sequence.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_SLPX,
    ST_PUSH,
    ST_VEC,
    ST_JMP,
    ST_POP
  } seq_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0] lower_set;

  // lower_set[i]: some request below i is pending
  assign lower_set[0] = 1'b0;
  for (genvar g = 1; g < N; g++) begin : g_lower
    assign lower_set[g] = lower_set[g-1] | req_i[g-1];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !lower_set[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_stack_port.sv
module irq_stack_port #(
  parameter int unsigned SP_W    = 8,
  parameter int unsigned PC_W    = 12,
  parameter logic [SP_W-1:0] SP_INIT = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            push_hi_i,
  input  logic            pop_i,
  input  logic            pop_hi_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [7:0]      rdata_i,
  output logic            we_o,
  output logic            re_o,
  output logic [SP_W-1:0] addr_o,
  output logic [7:0]      wdata_o,
  output logic [SP_W-1:0] sp_o,
  output logic [PC_W-1:0] ret_pc_o
);
  logic [SP_W-1:0] sp_q;
  logic [7:0]      hi_q, lo_q;
  logic [15:0]     pc_ext, ret_ext;

  assign pc_ext  = 16'(pc_i);
  assign ret_ext = {hi_q, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= SP_INIT;
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (push_i)     sp_q <= sp_q - SP_W'(1);
      else if (pop_i) sp_q <= sp_q + SP_W'(1);
      if (pop_i) begin
        if (pop_hi_i) hi_q <= rdata_i;
        else          lo_q <= rdata_i;
      end
    end
  end

  assign we_o     = push_i;
  assign re_o     = pop_i;
  assign addr_o   = pop_i ? sp_q + SP_W'(1) : sp_q;
  assign wdata_o  = push_hi_i ? pc_ext[15:8] : pc_ext[7:0];
  assign sp_o     = sp_q;
  assign ret_pc_o = ret_ext[PC_W-1:0];
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int unsigned ENTRY_CYC = 4,
  parameter int unsigned WAKE_XTRA = 4,
  parameter int unsigned JMP_CYC   = 3,
  parameter int unsigned RET_CYC   = 4,
  parameter int unsigned CNT_W     = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_req_i,
  input  logic gie_we_i,
  input  logic gie_wdata_i,
  input  logic mc_busy_i,
  input  logic sleep_i,
  input  logic wake_ready_i,
  input  logic reti_i,
  output logic accept_o,
  output logic gie_o,
  output logic push_o,
  output logic push_hi_o,
  output logic pop_o,
  output logic pop_hi_o,
  output logic vec_o,
  output logic handler_o,
  output logic ret_o,
  output logic stall_o
);
  seq_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic gie_q;
  logic start_ret, accept, last_cnt;

  assign start_ret = (state_q == ST_IDLE) && reti_i;
  assign accept    = (state_q == ST_IDLE) && !reti_i && any_req_i && gie_q && !mc_busy_i;

  always_comb begin
    unique case (state_q)
      ST_SLPX: last_cnt = (cnt_q == CNT_W'(WAKE_XTRA - 1));
      ST_PUSH: last_cnt = (cnt_q == CNT_W'(ENTRY_CYC - 1));
      ST_JMP:  last_cnt = (cnt_q == CNT_W'(JMP_CYC - 1));
      ST_POP:  last_cnt = (cnt_q == CNT_W'(RET_CYC - 1));
      default: last_cnt = 1'b1;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ret)   state_d = ST_POP;
        else if (accept) state_d = sleep_i ? ST_WAKE : ST_PUSH;
      end
      ST_WAKE: if (wake_ready_i) state_d = ST_SLPX;
      ST_SLPX: if (last_cnt) state_d = ST_PUSH;
      ST_PUSH: if (last_cnt) state_d = ST_VEC;
      ST_VEC:  state_d = ST_JMP;
      ST_JMP:  if (last_cnt) state_d = ST_IDLE;
      ST_POP:  if (last_cnt) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      gie_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_d != state_q) ? '0 : cnt_q + CNT_W'(1);
      if (accept)                                  gie_q <= 1'b0;
      else if (state_q == ST_POP && last_cnt)      gie_q <= 1'b1;
      else if (state_q == ST_IDLE && !start_ret && gie_we_i) gie_q <= gie_wdata_i;
    end
  end

  assign accept_o  = accept;
  assign gie_o     = gie_q;
  assign push_o    = (state_q == ST_PUSH) && (cnt_q < CNT_W'(2));
  assign push_hi_o = (state_q == ST_PUSH) && (cnt_q == CNT_W'(1));
  assign pop_o     = (state_q == ST_POP) && (cnt_q < CNT_W'(2));
  assign pop_hi_o  = (state_q == ST_POP) && (cnt_q == CNT_W'(0));
  assign vec_o     = (state_q == ST_VEC);
  assign handler_o = (state_q == ST_JMP) && last_cnt;
  assign ret_o     = (state_q == ST_POP) && last_cnt;
  assign stall_o   = (state_q != ST_IDLE);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned NUM_IRQ   = 8,
  parameter int unsigned PC_W      = 12,
  parameter int unsigned SP_W      = 8,
  parameter logic [SP_W-1:0] SP_INIT = '1,
  parameter int unsigned ENTRY_CYC = 4,
  parameter int unsigned WAKE_XTRA = 4,
  parameter int unsigned JMP_CYC   = 3,
  parameter int unsigned RET_CYC   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_req_i,
  input  logic               gie_we_i,
  input  logic               gie_wdata_i,
  input  logic               mc_busy_i,
  input  logic               sleep_i,
  input  logic               wake_ready_i,
  input  logic               reti_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [7:0]         stk_rdata_i,
  output logic               stk_we_o,
  output logic               stk_re_o,
  output logic [SP_W-1:0]    stk_addr_o,
  output logic [7:0]         stk_wdata_o,
  output logic [SP_W-1:0]    sp_o,
  output logic               vec_valid_o,
  output logic [PC_W-1:0]    vec_addr_o,
  output logic [NUM_IRQ-1:0] irq_ack_o,
  output logic               handler_start_o,
  output logic               ret_valid_o,
  output logic [PC_W-1:0]    ret_pc_o,
  output logic               gie_o,
  output logic               stall_o
);
  localparam int unsigned IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int unsigned MAX_C = max2(max2(ENTRY_CYC, WAKE_XTRA), max2(JMP_CYC, RET_CYC));
  localparam int unsigned CNT_W = $clog2(MAX_C + 1);

  logic             any_req, accept, push, push_hi, pop, pop_hi, vec;
  logic [IDX_W-1:0] win_idx, idx_q;
  logic [PC_W-1:0]  pc_q, idx_ext;

  irq_prio_enc #(.N(NUM_IRQ), .IDX_W(IDX_W)) u_prio (
    .req_i (irq_req_i),
    .any_o (any_req),
    .idx_o (win_idx)
  );

  irq_seq_fsm #(
    .ENTRY_CYC(ENTRY_CYC), .WAKE_XTRA(WAKE_XTRA),
    .JMP_CYC(JMP_CYC), .RET_CYC(RET_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .any_req_i    (any_req),
    .gie_we_i     (gie_we_i),
    .gie_wdata_i  (gie_wdata_i),
    .mc_busy_i    (mc_busy_i),
    .sleep_i      (sleep_i),
    .wake_ready_i (wake_ready_i),
    .reti_i       (reti_i),
    .accept_o     (accept),
    .gie_o        (gie_o),
    .push_o       (push),
    .push_hi_o    (push_hi),
    .pop_o        (pop),
    .pop_hi_o     (pop_hi),
    .vec_o        (vec),
    .handler_o    (handler_start_o),
    .ret_o        (ret_valid_o),
    .stall_o      (stall_o)
  );

  // winner and return address frozen when the interrupt is taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      pc_q  <= '0;
    end else if (accept) begin
      idx_q <= win_idx;
      pc_q  <= pc_i;
    end
  end

  irq_stack_port #(.SP_W(SP_W), .PC_W(PC_W), .SP_INIT(SP_INIT)) u_stack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push),
    .push_hi_i (push_hi),
    .pop_i     (pop),
    .pop_hi_i  (pop_hi),
    .pc_i      (pc_q),
    .rdata_i   (stk_rdata_i),
    .we_o      (stk_we_o),
    .re_o      (stk_re_o),
    .addr_o    (stk_addr_o),
    .wdata_o   (stk_wdata_o),
    .sp_o      (sp_o),
    .ret_pc_o  (ret_pc_o)
  );

  assign idx_ext     = PC_W'(idx_q);
  assign vec_valid_o = vec;
  assign vec_addr_o  = vec ? {idx_ext[PC_W-2:0], 1'b0} : '0;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_ack
    assign irq_ack_o[g] = vec && (idx_q == IDX_W'(g));
  end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned PC_W    = 12,
  parameter int unsigned SP_W    = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               stk_we_o,
  input logic               stk_re_o,
  input logic [SP_W-1:0]    stk_addr_o,
  input logic [SP_W-1:0]    sp_o,
  input logic               vec_valid_o,
  input logic [PC_W-1:0]    vec_addr_o,
  input logic [NUM_IRQ-1:0] irq_ack_o,
  input logic               handler_start_o,
  input logic               ret_valid_o,
  input logic               gie_o,
  input logic               stall_o
);
  logic [SP_W-1:0] sp_inc, sp_dec;
  assign sp_inc = sp_o + SP_W'(1);
  assign sp_dec = sp_o - SP_W'(1);

  AST_WE_IN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni) stk_we_o |-> stall_o); // R11
  AST_PUSH_AT_SP: assert property (@(posedge clk_i) disable iff (!rst_ni) stk_we_o |-> (stk_addr_o == sp_o)); // R3
  AST_PUSH_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni) stk_we_o |=> (sp_o == $past(sp_dec))); // R3
  AST_POP_ABOVE_SP: assert property (@(posedge clk_i) disable iff (!rst_ni) stk_re_o |-> (stk_addr_o == sp_inc)); // R9
  AST_POP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni) stk_re_o |=> (sp_o == $past(sp_inc))); // R9
  AST_NO_WE_RE: assert property (@(posedge clk_i) disable iff (!rst_ni) !(stk_we_o && stk_re_o)); // R9
  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(irq_ack_o)); // R4
  AST_ACK_WITH_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni) (|irq_ack_o) == vec_valid_o); // R4
  AST_VEC_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni) vec_valid_o |-> !vec_addr_o[0]); // R4
  AST_GIE_LOW_AT_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni) vec_valid_o |-> !gie_o); // R6
  AST_GIE_AFTER_RET: assert property (@(posedge clk_i) disable iff (!rst_ni) ret_valid_o |=> gie_o); // R9
  AST_HANDLER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni) handler_start_o |=> !stall_o); // R5
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.NUM_IRQ(NUM_IRQ), .PC_W(PC_W), .SP_W(SP_W)) u_chk (.*);

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;
  localparam int NI  = 8;
  localparam int PW  = 12;
  localparam int SW  = 8;
  localparam logic [SW-1:0] SPI = 8'hF0;
  localparam int XTRA = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NI-1:0] irq_req = '0;
  logic gie_we = 0, gie_wd = 0, busy = 0, slp = 0, wrdy = 0, reti = 0;
  logic [PW-1:0] pc = '0;
  logic [7:0] rdata;
  logic we, re, vv, hs, rv, gie, stall;
  logic [SW-1:0] addr, sp;
  logic [7:0] wdata;
  logic [PW-1:0] vaddr, rpc;
  logic [NI-1:0] ack;

  logic [7:0] smem [0:(1<<SW)-1];
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [SW-1:0] exp_sp;
  logic [PW-1:0] pc_stk [0:15];
  int depth = 0;

  always #4 clk = ~clk;

  irq_entry_seq #(.NUM_IRQ(NI), .PC_W(PW), .SP_W(SW), .SP_INIT(SPI)) u_irq_entry_seq (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq_req), .gie_we_i(gie_we), .gie_wdata_i(gie_wd),
    .mc_busy_i(busy), .sleep_i(slp), .wake_ready_i(wrdy), .reti_i(reti), .pc_i(pc),
    .stk_rdata_i(rdata), .stk_we_o(we), .stk_re_o(re), .stk_addr_o(addr), .stk_wdata_o(wdata),
    .sp_o(sp), .vec_valid_o(vv), .vec_addr_o(vaddr), .irq_ack_o(ack), .handler_start_o(hs),
    .ret_valid_o(rv), .ret_pc_o(rpc), .gie_o(gie), .stall_o(stall)
  );

  always @(posedge clk) if (we) smem[addr] <= wdata;
  assign rdata = smem[addr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lowest(input logic [NI-1:0] m);
    for (int i = 0; i < NI; i++) if (m[i]) return i;
    return 0;
  endfunction

  task automatic set_gie(input logic v);
    gie_we = 1; gie_wd = v;
    @(negedge clk);
    gie_we = 0;
    chk("R10 gie write in idle", 32'(gie), 32'(v));
  endtask

  // called at a negedge while idle with gie=1
  task automatic run_irq(input logic [NI-1:0] mask, input logic [PW-1:0] p,
                         input bit sleep, input int wdel);
    int off, idx;
    logic [15:0] pe;
    off = sleep ? wdel + 1 + XTRA : 0;
    idx = lowest(mask);
    pe = 16'(p);
    irq_req = mask; pc = p; slp = sleep;
    for (int k = 1; k <= off + 9; k++) begin
      @(negedge clk);
      if (k == off + 9) begin
        chk("R5 idle after jump", 32'(stall), 0);
        chk("R3 sp after two pushes", 32'(sp), 32'(exp_sp - SW'(2)));
        chk("R10 gie write ignored mid-sequence", 32'(gie), 0);
      end else begin
        chk("R11 stall in window", 32'(stall), 1);
        chk("R3 push strobe", 32'(we), 32'(k == off + 1 || k == off + 2));
        if (k == off + 1) begin
          chk("R3 low byte addr", 32'(addr), 32'(exp_sp));
          chk("R3 low byte data", 32'(wdata), 32'(pe[7:0]));
        end
        if (k == off + 2) begin
          chk("R3 high byte addr", 32'(addr), 32'(exp_sp - SW'(1)));
          chk("R3 high byte data", 32'(wdata), 32'(pe[15:8]));
        end
        chk(sleep ? "R8 vector timing after wake" : "R4 vector timing", 32'(vv), 32'(k == off + 5));
        if (k == off + 5) begin
          chk("R4 vector address", 32'(vaddr), 32'(2 * idx));
          chk("R4 ack one-hot", 32'(ack), 32'(1 << idx));
          chk("R6 gie cleared on entry", 32'(gie), 0);
          irq_req = '0;
        end
        chk("R5 handler start", 32'(hs), 32'(k == off + 8));
      end
      slp = 0;
      if (sleep && k == wdel + 1) wrdy = 1; else wrdy = 0;
      gie_we = (k == 2); gie_wd = 1;
    end
    gie_we = 0;
    exp_sp = exp_sp - SW'(2);
    pc_stk[depth] = p;
    depth++;
  endtask

  task automatic run_reti(input logic [NI-1:0] pend);
    logic [PW-1:0] ep;
    depth--;
    ep = pc_stk[depth];
    reti = 1; irq_req = pend;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      reti = 0; irq_req = '0;
      if (k == 5) begin
        chk("R9 idle after return", 32'(stall), 0);
        chk("R9 gie set after return", 32'(gie), 1);
        chk("R9 sp raised by two", 32'(sp), 32'(exp_sp + SW'(2)));
      end else begin
        chk("R11 stall in return", 32'(stall), 1);
        chk(pend != 0 ? "R12 return wins, pop strobe" : "R9 pop strobe", 32'(re), 32'(k <= 2));
        chk(pend != 0 ? "R12 return wins, no push" : "R9 no push", 32'(we), 0);
        if (k == 1) chk("R9 high byte addr", 32'(addr), 32'(exp_sp + SW'(1)));
        if (k == 2) chk("R9 low byte addr", 32'(addr), 32'(exp_sp + SW'(2)));
        chk("R9 ret valid", 32'(rv), 32'(k == 4));
        if (k == 4) chk("R9 restored pc", 32'(rpc), 32'(ep));
      end
    end
    exp_sp = exp_sp + SW'(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    exp_sp = SPI;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 stall reset", 32'(stall), 0);
    chk("R1 gie reset", 32'(gie), 0);
    chk("R1 sp reset", 32'(sp), 32'(SPI));
    chk("R1 strobes reset", 32'({we, re, vv, hs, rv}), 0);

    // R2: gie low blocks the request
    irq_req = 8'h10;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R2 no entry with gie low", 32'({stall, we}), 0);
    end
    irq_req = '0;
    set_gie(1);

    // R7: busy holds the request off
    busy = 1; irq_req = 8'h04;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R7 held during multi-cycle instruction", 32'({stall, we}), 0);
    end
    busy = 0;
    run_irq(8'h04, 12'hA5C, 0, 0);
    run_reti('0);

    // priority across mixed requests
    run_irq(8'hA8, 12'h3F1, 0, 0);
    run_reti('0);
    run_irq(8'h81, 12'h07E, 0, 0);
    run_reti('0);

    // R8: sleep with zero and longer wake waits
    run_irq(8'h02, 12'h123, 1, 0);
    run_reti('0);
    run_irq(8'h40, 12'hFED, 1, 3);
    run_reti('0);

    // nested: handler re-enables, second interrupt, LIFO return
    run_irq(8'h20, 12'h9AB, 0, 0);
    set_gie(1);
    run_irq(8'h01, 12'h456, 0, 0);
    run_reti('0);
    run_reti('0);

    // R12: reti and an acceptable request together
    run_irq(8'h08, 12'h5A5, 0, 0);
    set_gie(1);
    run_reti(8'h08);

    // constrained random
    for (int it = 0; it < 40; it++) begin
      logic [NI-1:0] m;
      bit s;
      m = NI'($urandom());
      if (m == 0) m = 8'h80;
      s = ($urandom() % 4) == 0;
      run_irq(m, PW'($urandom()), s, int'($urandom() % 6));
      if (($urandom() % 3) == 0) begin
        set_gie(1);
        run_irq(NI'(1 << ($urandom() % NI)), PW'($urandom()), 0, 0);
        run_reti('0);
      end
      run_reti('0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule